// File: doc/BRIEF.md
# Single-Bit Shift and Rotate Unit

This block performs one-position shifts and rotates on a single 16-bit register operand for a small processor datapath. Every operation has one source and no second operand. The block takes an opcode, the operand and the current carry flag. It returns the shifted word and fresh zero, negative and carry flags. The overflow flag is not part of its interface, so it never changes here.

Eight opcodes, from 0x46 to 0x4D, form the group. Bit 0 of the opcode sets the direction: even opcodes shift left and odd opcodes shift right. Bits 2:1 of the offset from 0x46 set how the vacated bit is filled. Offset pair 0 (SHL/SHR) fills with zero. Offset pair 1 (SHLC/SHRC) fills with the incoming carry. Offset pair 2 (ROL/ROR) fills with the bit that leaves the opposite end of the word. Offset pair 3 (ROLC/RORC) rotates through the carry as a 17-bit loop. In every case the bit shifted out of the word becomes the new carry.

A two-state controller (`ST_IDLE`, `ST_SHOW`) registers each accepted operation. Transitions:
- `ST_IDLE` goes to `ST_SHOW` when a valid in-group opcode arrives.
- `ST_SHOW` stays in `ST_SHOW` when another valid in-group opcode arrives.
- `ST_SHOW` returns to `ST_IDLE` on any other cycle.
- `ST_IDLE` stays in `ST_IDLE` on any other cycle.

Results therefore appear exactly one cycle after acceptance, and operations can be issued back to back.

Top module: `sru_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `out_valid`, `out_res`, `out_z`, `out_n` and `out_c` are all 0.
- R2: When `in_valid` is high with an opcode in 0x46..0x4D at a rising edge, `out_valid` is high during the following cycle and carries that operation's result. Consecutive accepted operations produce consecutive results in order.
- R3: An opcode outside 0x46..0x4D, or `in_valid` low, leaves `out_valid` low in the next cycle. In that case `out_res` and the flags keep their previous values.
- R4: SHL (0x46) gives `{val[14:0],0}` with C = val[15]. SHR (0x47) gives `{0,val[15:1]}` with C = val[0].
- R5: SHLC (0x48) gives `{val[14:0],cin}` with C = val[15]. SHRC (0x49) gives `{cin,val[15:1]}` with C = val[0].
- R6: ROL (0x4A) gives `{val[14:0],val[15]}` with C = val[15]. ROR (0x4B) gives `{val[0],val[15:1]}` with C = val[0].
- R7: ROLC (0x4C) gives `{val[14:0],cin}` with C = val[15]. RORC (0x4D) gives `{cin,val[15:1]}` with C = val[0]. These form a 17-bit rotation through carry.
- R8: For every accepted operation, Z is 1 exactly when the result is 0x0000, and N equals result bit 15.
- R9: For SHL, SHR, ROL and ROR, `in_carry` has no effect on the result or on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request |
| in_op | input | 8 | Opcode; only 0x46..0x4D are accepted |
| in_val | input | 16 | Register operand |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result valid this cycle |
| out_res | output | 16 | Shifted or rotated word |
| out_z | output | 1 | Zero flag |
| out_n | output | 1 | Negative flag |
| out_c | output | 1 | New carry flag |

## Verification
Two things can happen in the same cycle: presenting one result and accepting the next operation. The same holds when a rejected opcode arrives while a result is still displayed. The bench provokes both by issuing a long back-to-back stream with out-of-group opcodes and idle cycles placed between accepted ones. A scoreboard queue checks that each result appears exactly once, in order, one cycle after its request, and that a rejected request neither produces a result nor disturbs the held word. Directed corner words (0x8000, 0x0001, 0x0000, 0xFFFF) cover the cases where the carry, the zero flag and the negative flag switch.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [1:0] {
        FILL_ZERO  = 2'd0,
        FILL_CARRY = 2'd1,
        FILL_WRAP  = 2'd2
    } fill_t;

    typedef struct packed {
        logic  hit;
        logic  right;
        fill_t fill;
    } ctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } state_t;

endpackage

// File: rtl/sru_decode.sv
module sru_decode
    import sru_pkg::*;
#(
    parameter logic [7:0] OP_BASE = 8'h46
) (
    input  logic [7:0] op,
    output ctl_t       ctl
);
    localparam logic [7:0] OP_LAST = OP_BASE + 8'd7;

    logic [7:0] off;

    always_comb begin
        off       = op - OP_BASE;
        ctl.hit   = (op >= OP_BASE) && (op <= OP_LAST);
        ctl.right = off[0];
        unique case (off[2:1])
            2'd0:    ctl.fill = FILL_ZERO;
            2'd1:    ctl.fill = FILL_CARRY;
            2'd2:    ctl.fill = FILL_WRAP;
            default: ctl.fill = FILL_CARRY;
        endcase
    end
endmodule

// File: rtl/sru_core.sv
module sru_core
    import sru_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] val,
    input  logic             cin,
    input  ctl_t             ctl,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    logic fill;

    always_comb begin
        unique case (ctl.fill)
            FILL_ZERO:  fill = 1'b0;
            FILL_CARRY: fill = cin;
            FILL_WRAP:  fill = ctl.right ? val[0] : val[MSB];
            default:    fill = 1'b0;
        endcase
        cout = ctl.right ? val[0] : val[MSB];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign res[i] = ctl.right ? val[i+1] : fill;
        end else if (i == MSB) begin : g_hi
            assign res[i] = ctl.right ? fill : val[i-1];
        end else begin : g_mid
            assign res[i] = ctl.right ? val[i+1] : val[i-1];
        end
    end
endmodule

// File: rtl/sru_flags.sv
module sru_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] res,
    output logic             z,
    output logic             n
);
    assign z = ~|res;
    assign n = res[WIDTH-1];
endmodule

// File: rtl/sru_top.sv
module sru_top
    import sru_pkg::*;
#(
    parameter int         WIDTH   = 16,
    parameter logic [7:0] OP_BASE = 8'h46
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_op,
    input  logic [WIDTH-1:0] in_val,
    input  logic             in_carry,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_res,
    output logic             out_z,
    output logic             out_n,
    output logic             out_c
);
    localparam int         MSB    = WIDTH - 1;
    localparam logic [7:0] OP_ROL = OP_BASE + 8'd4;
    localparam logic [7:0] OP_RRC = OP_BASE + 8'd7;

    ctl_t             ctl;
    logic [WIDTH-1:0] nx_res;
    logic             nx_c, nx_z, nx_n, take;
    state_t           state, state_nx;

    sru_decode #(.OP_BASE(OP_BASE)) dec_i (.op(in_op), .ctl(ctl));

    sru_core #(.WIDTH(WIDTH)) core_i (
        .val(in_val), .cin(in_carry), .ctl(ctl), .res(nx_res), .cout(nx_c)
    );

    sru_flags #(.WIDTH(WIDTH)) flg_i (.res(nx_res), .z(nx_z), .n(nx_n));

    assign take = in_valid && ctl.hit;

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = take ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nx = take ? ST_SHOW : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_res <= '0;
            out_z   <= 1'b0;
            out_n   <= 1'b0;
            out_c   <= 1'b0;
        end else if (take) begin
            out_res <= nx_res;
            out_z   <= nx_z;
            out_n   <= nx_n;
            out_c   <= nx_c;
        end
    end

    assign out_valid = (state == ST_SHOW);

    // R2
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= OP_BASE && in_op <= OP_RRC) |=> out_valid);

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_op >= OP_BASE && in_op <= OP_RRC)
            |=> (!out_valid && $stable(out_res) && $stable(out_c)));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_z == (out_res == '0)));

    // R8
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_n == out_res[MSB]));

    // R6
    rol_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_ROL)
            |=> (out_res[0] == $past(in_val[MSB]) && out_c == $past(in_val[MSB])));

    // R7
    rorc_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_RRC)
            |=> (out_res[MSB] == $past(in_carry) && out_c == $past(in_val[0])));
endmodule

// File: tb/sru_top_tb.sv
module sru_top_tb_top;

    typedef struct {
        logic [15:0] r;
        logic        z, n, c;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_op = 8'h00;
    logic [15:0] in_val = 16'h0000;
    logic        in_carry = 1'b0;
    logic        out_valid, out_z, out_n, out_c;
    logic [15:0] out_res;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];
    logic [15:0] last_res = 16'h0000;
    logic        last_c = 1'b0;
    bit          done = 0;

    always #5 clk = ~clk;

    sru_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_val(in_val), .in_carry(in_carry), .out_valid(out_valid),
        .out_res(out_res), .out_z(out_z), .out_n(out_n), .out_c(out_c)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [7:0] op, input logic [15:0] v,
                                   input logic ci);
        exp_t e;
        case (op)
            8'h46: begin e.r = v << 1;             e.c = v[15]; e.req = "R4"; end
            8'h47: begin e.r = v >> 1;             e.c = v[0];  e.req = "R4"; end
            8'h48: begin e.r = {v[14:0], ci};      e.c = v[15]; e.req = "R5"; end
            8'h49: begin e.r = {ci, v[15:1]};      e.c = v[0];  e.req = "R5"; end
            8'h4A: begin e.r = {v[14:0], v[15]};   e.c = v[15]; e.req = "R6"; end
            8'h4B: begin e.r = {v[0], v[15:1]};    e.c = v[0];  e.req = "R6"; end
            8'h4C: begin e.r = {v[14:0], ci};      e.c = v[15]; e.req = "R7"; end
            default: begin e.r = {ci, v[15:1]};    e.c = v[0];  e.req = "R7"; end
        endcase
        e.z = (e.r == 16'h0000);
        e.n = e.r[15];
        return e;
    endfunction

    // driver: one request per call, pushes the expected item when accepted
    task automatic issue(input bit vld, input logic [7:0] op,
                         input logic [15:0] v, input logic ci);
        @(negedge clk);
        in_valid = vld;
        in_op    = op;
        in_val   = v;
        in_carry = ci;
        if (vld && op >= 8'h46 && op <= 8'h4D) sb.push_back(model(op, v, ci));
    endtask

    // monitor: pops and compares every presented result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected result", out_res, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_res == e.r, e.req, "result", out_res, e.r);
                    check(out_c == e.c, e.req, "carry", out_c, e.c);
                    check(out_z == e.z, "R8", "zero", out_z, e.z);
                    check(out_n == e.n, "R8", "negative", out_n, e.n);
                    last_res = out_res;
                    last_c   = out_c;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 0 && out_res == 0 && {out_z, out_n, out_c} == 0,
              "R1", "reset outputs", {out_valid, out_z, out_n, out_c, out_res}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_res == 0, "R1", "after reset",
              {out_valid, out_res}, 0);

        // corner words
        issue(1, 8'h46, 16'h8000, 1'b0);   // R4: 0, Z=1, C=1
        issue(1, 8'h47, 16'h0001, 1'b1);   // R4 / R9
        issue(1, 8'h4B, 16'h0001, 1'b0);   // R6: 0x8000 N=1
        issue(1, 8'h4A, 16'h8000, 1'b0);   // R6
        issue(1, 8'h4D, 16'h0001, 1'b0);   // R7: 0, Z=1, C=1
        issue(1, 8'h4C, 16'hFFFF, 1'b0);   // R7
        issue(1, 8'h49, 16'h0000, 1'b1);   // R5: 0x8000
        issue(1, 8'h48, 16'h7FFF, 1'b1);   // R5
        issue(0, 8'h00, 16'h0000, 1'b0);
        @(negedge clk);

        // R9: carry-in must not matter for plain ops
        for (int k = 0; k < 4; k++) begin
            logic [7:0] op9;
            logic [15:0] r9a, r9b;
            logic c9a, c9b;
            op9 = (k < 2) ? 8'h46 + 8'(k) : 8'h4A + 8'(k - 2);
            issue(1, op9, 16'hA5C3, 1'b0);
            issue(0, 8'h00, 16'h0000, 1'b0);
            @(negedge clk);
            r9a = out_res; c9a = out_c;
            issue(1, op9, 16'hA5C3, 1'b1);
            issue(0, 8'h00, 16'h0000, 1'b0);
            @(negedge clk);
            r9b = out_res; c9b = out_c;
            check(r9a == r9b && c9a == c9b, "R9", "cin sensitivity",
                  {c9b, r9b}, {c9a, r9a});
        end

        // R3: rejected opcodes neither emit nor disturb
        for (int k = 0; k < 6; k++) begin
            logic [7:0] bad;
            bad = (k % 2 == 0) ? 8'h45 : 8'h4E + 8'(k);
            issue(1, 8'h4A, 16'h1234 + 16'(k), 1'(k));
            issue(1, bad, 16'hFFFF, 1'b1);
            @(negedge clk);
            check(out_valid == 0, "R3", "valid after reject", out_valid, 0);
            check(out_res == last_res && out_c == last_c, "R3", "held word",
                  {out_c, out_res}, {last_c, last_res});
            in_valid = 1'b0;
        end

        // R2: long mixed stream, back to back with gaps
        for (int k = 0; k < 300; k++) begin
            logic [31:0] rnd;
            rnd = $urandom;
            if (rnd[31:29] == 3'd0)
                issue(rnd[28], 8'h50, rnd[15:0], rnd[16]);
            else
                issue(rnd[28] | rnd[27], 8'h46 + {5'd0, rnd[26:24]}, rnd[15:0], rnd[16]);
        end
        issue(0, 8'h00, 16'h0000, 1'b0);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", "pending results", sb.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule